// File: doc/BRIEF.md
# EEPROM Word Address Pointer

This block keeps the internal byte address of a 32 KiB serial EEPROM model. The protocol engine loads it from the two address bytes of a write command. It then steps the pointer once for every data byte that moves across the bus. The memory array and the protocol engine both read the current address from the registered output.

How the pointer steps depends on the direction of the byte. After a written byte, only the offset inside the 64-byte page moves, so a long write sequence folds back onto the start of the same page. After a read byte, the whole address moves, so a sequential read crosses page boundaries and wraps from the top of the array to zero. Nothing clears the pointer except reset. It therefore keeps the next address between transactions, and a current-address read uses that value.

Top module: `eep_addr_ptr`

## Requirements
- R1: While rst_ni is low, addr_o is 0, and it stays 0 until the first load or step.
- R2: When load_i is high at a clock edge, addr_o after that edge equals load_addr_i[14:0]. Bit 15 of load_addr_i (the top bit of the first address byte) has no effect.
- R3: A write step (step_i=1, step_rd_i=0, load_i=0) adds one to addr_o[5:0] and leaves addr_o[14:6] unchanged.
- R4: A write step with addr_o[5:0]=63 sets addr_o[5:0] to 0 and keeps the same page in addr_o[14:6].
- R5: A read step (step_i=1, step_rd_i=1, load_i=0) adds one to the full 15-bit addr_o.
- R6: A read step at addr_o=0x7FFF sets addr_o to 0.
- R7: A read step with addr_o[5:0]=63 moves addr_o to offset 0 of the next page.
- R8: When load_i and step_i are both high in the same cycle, the load wins and the step is dropped.
- R9: With load_i=0 and step_i=0, addr_o holds its value for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load strobe for the address taken from the command |
| load_addr_i | input | 16 | The two address bytes, first byte in bits 15:8 |
| step_i | input | 1 | Advance strobe, one pulse per byte transferred |
| step_rd_i | input | 1 | Step mode: 1 = read byte (full wrap), 0 = written byte (page wrap) |
| addr_o | output | 15 | Current word address |

## Verification
The assertions make two assumptions about the inputs. Every strobe is a clean level sampled at the rising edge, and step_rd_i carries a known value whenever step_i is high. They do not assume that load and step are exclusive, because R8 defines what happens when both are high. The stimulus changes inputs only on the falling edge. It draws step_rd_i from $urandom whenever a step is issued, and it fires load and step together on purpose. The directed cases place the pointer on page ends and on the last address, so that the wrap paths run under both step modes.

// File: rtl/eep_ptr_pkg.sv
package eep_ptr_pkg;
  localparam int unsigned ADDR_W = 15;
  localparam int unsigned PAGE_W = 6;
  localparam int unsigned ROW_W  = ADDR_W - PAGE_W;
  localparam int unsigned CMD_W  = 16;

  typedef enum logic {
    STEP_WR = 1'b0,
    STEP_RD = 1'b1
  } step_mode_e;
endpackage

// File: rtl/eep_ptr_offset.sv
module eep_ptr_offset #(
  parameter int unsigned OFF_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [OFF_W-1:0] load_val_i,
  input  logic             step_i,
  output logic [OFF_W-1:0] off_o,
  output logic             at_end_o
);
  localparam logic [OFF_W-1:0] OffLast = '1;

  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     off_q <= '0;
    else if (load_i) off_q <= load_val_i;
    else if (step_i) off_q <= off_q + 1'b1;
  end

  assign off_o    = off_q;
  assign at_end_o = (off_q == OffLast);
endmodule

// File: rtl/eep_ptr_row.sv
module eep_ptr_row #(
  parameter int unsigned ROW_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ROW_W-1:0] load_val_i,
  input  logic             inc_i,
  output logic [ROW_W-1:0] row_o
);
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_q <= '0;
    else if (load_i) row_q <= load_val_i;
    else if (inc_i)  row_q <= row_q + 1'b1;
  end

  assign row_o = row_q;
endmodule

// File: rtl/eep_addr_ptr.sv
module eep_addr_ptr
  import eep_ptr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CMD_W-1:0]  load_addr_i,
  input  logic              step_i,
  input  logic              step_rd_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [PAGE_W-1:0] off;
  logic [ROW_W-1:0]  row;
  logic              off_at_end;
  logic              row_inc;
  step_mode_e        mode;

  assign mode = step_mode_e'(step_rd_i);

  eep_ptr_offset #(.OFF_W(PAGE_W)) u_offset (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .load_val_i (load_addr_i[PAGE_W-1:0]),
    .step_i     (step_i),
    .off_o      (off),
    .at_end_o   (off_at_end)
  );

  // row moves only when a read byte leaves the last offset of a page
  assign row_inc = step_i && !load_i && (mode == STEP_RD) && off_at_end;

  eep_ptr_row #(.ROW_W(ROW_W)) u_row (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .load_val_i (load_addr_i[ADDR_W-1:PAGE_W]),
    .inc_i      (row_inc),
    .row_o      (row)
  );

  assign addr_o = {row, off};

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(load_addr_i[ADDR_W-1:0]));

  assert_wr_page_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !step_rd_i) |=>
      (addr_o[ADDR_W-1:PAGE_W] == $past(addr_o[ADDR_W-1:PAGE_W])) &&
      (addr_o[PAGE_W-1:0] == $past(addr_o[PAGE_W-1:0]) + 1'b1));

  assert_wr_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !step_rd_i && (addr_o[PAGE_W-1:0] == '1)) |=>
      addr_o[PAGE_W-1:0] == '0);

  assert_rd_inc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && step_rd_i) |=> addr_o == $past(addr_o) + 1'b1);

  assert_rd_top_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && step_rd_i && (addr_o == '1)) |=> addr_o == '0);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(addr_o));

  always_comb begin
    if (!rst_ni) assert_reset_R1: assert (addr_o == '0);
  end
endmodule

// File: tb/eep_addr_ptr_bench.sv
`timescale 1ns/1ps
module eep_addr_ptr_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [15:0] load_addr_i = '0;
  logic        step_i = 1'b0;
  logic        step_rd_i = 1'b0;
  logic [14:0] addr_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [14:0] exp_addr = '0;

  always #2.5 clk_i = ~clk_i;

  eep_addr_ptr u_eep_addr_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .load_addr_i(load_addr_i),
    .step_i(step_i), .step_rd_i(step_rd_i), .addr_o(addr_o)
  );

  function automatic logic [14:0] model_next(logic [14:0] cur, logic ld,
                                             logic [15:0] la, logic st, logic rd);
    if (ld) return la[14:0];
    if (!st) return cur;
    if (rd) return cur + 15'd1;
    return {cur[14:6], cur[5:0] + 6'd1};
  endfunction

  function automatic string pick_tag(logic [14:0] cur, logic ld, logic st, logic rd);
    if (ld && st) return "R8";
    if (ld) return "R2";
    if (!st) return "R9";
    if (rd) begin
      if (cur == 15'h7fff) return "R6";
      if (cur[5:0] == 6'h3f) return "R7";
      return "R5";
    end
    if (cur[5:0] == 6'h3f) return "R4";
    return "R3";
  endfunction

  task automatic check(string tag, logic [14:0] exp);
    checks++;
    if (addr_o !== exp) begin
      fails++;
      $display("FAIL %s addr_o=%h expected=%h", tag, addr_o, exp);
    end
  endtask

  task automatic op(logic ld, logic [15:0] la, logic st, logic rd);
    string tag;
    tag = pick_tag(exp_addr, ld, st, rd);
    load_i = ld; load_addr_i = la; step_i = st; step_rd_i = rd;
    exp_addr = model_next(exp_addr, ld, la, st, rd);
    @(negedge clk_i);
    check(tag, exp_addr);
    load_i = 1'b0; step_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    check("R1", 15'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", 15'd0);
    // directed corners
    op(1, 16'h8abf, 0, 0);            // R2: top bit ignored
    op(0, 16'h0, 1, 0);               // R4: page wrap on write
    op(0, 16'h0, 1, 0);               // R3
    op(1, 16'h013f, 0, 0);
    op(0, 16'h0, 1, 1);               // R7: read crosses page
    op(1, 16'h7fff, 0, 0);
    op(0, 16'h0, 1, 1);               // R6: read wraps to 0
    op(1, 16'h7fff, 0, 0);
    op(0, 16'h0, 1, 0);               // R4 at top page
    op(1, 16'h1234, 1, 1);            // R8
    op(1, 16'h0555, 1, 0);            // R8
    for (int i = 0; i < 5; i++) op(0, 16'h0, 0, 0);  // R9
    for (int i = 0; i < 70; i++) op(0, 16'h0, 1, 0); // long write, R3/R4
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic ld, st, rd;
      logic [15:0] la;
      r  = $urandom % 16;
      ld = (r < 2);
      st = (r >= 1) && (r < 13);
      rd = 1'($urandom);
      la = 16'($urandom);
      if ($urandom % 8 == 0) la[5:0] = 6'h3f;
      if ($urandom % 16 == 0) la[14:0] = 15'h7fff;
      op(ld, la, st, rd);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule